// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This block keeps wall-clock time and a calendar from a single-cycle tick that arrives once per second. It holds second, minute and hour counters together with day of month, day of week, month and a two-digit year. It works out month lengths and leap years itself, and it can move the hour forward or back for summer time on dates and hours that software chooses.

Software reaches every setting through a small register bus. A request is a valid/ready handshake. A read answers one cycle later on a response strobe. A control bit selects packed BCD or plain binary for all time-valued registers, and that choice applies to both directions. An alarm comparator watches the running time. It sets a sticky flag that software clears by writing a one. It drives an interrupt when the interrupt is enabled, and it drives a wake output that does not depend on that enable.

Top module: `cal_rtc`

## Requirements
- R1: After reset the time reads 00:00:00. Day of month is 1, month is 1, year is 0 and day of week is 0. Control (address 7) reads 0, the alarm flag is 0, and both alarm_irq and alarm_wake are low.
- R2: On each tick the second advances. 59 wraps to 0 and advances the minute. Minute 59 wraps and advances the hour. Hour 23 wraps to 0 and advances the day of month and the day of week; day of week runs 0..6 and 6 wraps to 0.
- R3: Months 4, 6, 9 and 11 have 30 days and the other months have 31, except month 2. After the last day comes day 1 of the next month, and month 12 wraps to 1.
- R4: The year is held as 0..99. Month 2 has 29 days when the year is a multiple of 4 and 28 days otherwise. Year 99 wraps to 0 when month 12 wraps.
- R5: Control bit 0 = 1 selects packed BCD (tens in bits 7:4, units in bits 3:0) for reads and writes of addresses 0-6, 8-13 and 15-20. With bit 0 = 0 those addresses use binary. Control (7) and status (14) are always binary.
- R6: A write to a time address (0 sec, 1 min, 2 hour, 3 day, 4 weekday, 5 month, 6 year) loads the running counter. The new value reads back right away, and the counter then keeps counting from it.
- R7: With control bit 3 set, the hour rollover on the start date (month at 15, day at 16) skips the start hour at 17. The time goes from (hour 17 - 1):59:59 straight to (hour 17 + 1):00:00. The start hour must be 1..22.
- R8: With control bit 3 set, at the end of the end hour (address 20) on the end date (month at 18, day at 19), the hour repeats once and the time returns to that hour's :00:00. The next pass through that hour advances normally. The once-only guard is re-armed at midnight.
- R9: The alarm time sits at addresses 10 (hour), 9 (min) and 8 (sec). The alarm flag (status bit 0) sets in the cycle after the time first equals the alarm time. Writing 1 to status bit 0 clears the flag, and a match that continues does not set it again.
- R10: alarm_irq is high exactly while the alarm flag and control bit 1 are both set.
- R11: With control bit 2 set, a match also needs day of month, month and year equal to addresses 11, 12 and 13.
- R12: alarm_wake follows the alarm flag whatever the value of control bit 1.
- R13: bus_ready is low in a cycle with tick_1hz high, and high otherwise. A read accepted at a clock edge gives rd_valid and rd_data on the following edge. Reads of addresses 21-31 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Register request accepted when high with bus_valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read response strobe, one cycle, no back-pressure |
| rd_data | output | 8 | Read response data |
| alarm_irq | output | 1 | Alarm interrupt |
| alarm_wake | output | 1 | Alarm wake signal, independent of the interrupt enable |

## Verification
The assertions assume that tick_1hz is a single-cycle pulse. They also assume that software writes only legal values: seconds and minutes 0..59, hours 0..23, a day that exists in the chosen month and year, and month 1..12. Under those inputs the counters never leave their ranges. The bench builds every loaded date from the month length it computes itself, and it never issues a bus request while a tick is high. The random phase keeps summer time switched off, and that mode is covered by directed cases.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 8;
  localparam int FIELD_W = 7;

  typedef logic [FIELD_W-1:0] fld_t;

  localparam fld_t SEC_TOP  = 7'd59;
  localparam fld_t MIN_TOP  = 7'd59;
  localparam fld_t HOUR_TOP = 7'd23;
  localparam fld_t WDAY_TOP = 7'd6;
  localparam fld_t MON_TOP  = 7'd12;
  localparam fld_t YEAR_TOP = 7'd99;
  localparam fld_t ONE      = 7'd1;

  localparam logic [ADDR_W-1:0] A_SEC   = 5'd0;
  localparam logic [ADDR_W-1:0] A_MIN   = 5'd1;
  localparam logic [ADDR_W-1:0] A_HOUR  = 5'd2;
  localparam logic [ADDR_W-1:0] A_DATE  = 5'd3;
  localparam logic [ADDR_W-1:0] A_WDAY  = 5'd4;
  localparam logic [ADDR_W-1:0] A_MON   = 5'd5;
  localparam logic [ADDR_W-1:0] A_YEAR  = 5'd6;
  localparam logic [ADDR_W-1:0] A_CTRL  = 5'd7;
  localparam logic [ADDR_W-1:0] A_ASEC  = 5'd8;
  localparam logic [ADDR_W-1:0] A_AMIN  = 5'd9;
  localparam logic [ADDR_W-1:0] A_AHOUR = 5'd10;
  localparam logic [ADDR_W-1:0] A_ADATE = 5'd11;
  localparam logic [ADDR_W-1:0] A_AMON  = 5'd12;
  localparam logic [ADDR_W-1:0] A_AYEAR = 5'd13;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'd14;
  localparam logic [ADDR_W-1:0] A_SMON  = 5'd15;
  localparam logic [ADDR_W-1:0] A_SDAY  = 5'd16;
  localparam logic [ADDR_W-1:0] A_SHOUR = 5'd17;
  localparam logic [ADDR_W-1:0] A_EMON  = 5'd18;
  localparam logic [ADDR_W-1:0] A_EDAY  = 5'd19;
  localparam logic [ADDR_W-1:0] A_EHOUR = 5'd20;

  typedef struct packed {
    fld_t sec;
    fld_t min;
    fld_t hour;
    fld_t date;
    fld_t wday;
    fld_t month;
    fld_t year;
  } rtc_time_t;

  typedef struct packed {
    fld_t sec;
    fld_t min;
    fld_t hour;
    fld_t date;
    fld_t month;
    fld_t year;
  } rtc_alarm_t;

  typedef struct packed {
    fld_t mon_on;
    fld_t day_on;
    fld_t hour_on;
    fld_t mon_off;
    fld_t day_off;
    fld_t hour_off;
  } rtc_dst_t;

  typedef struct packed {
    logic dst_en;
    logic date_match;
    logic irq_en;
    logic bcd;
  } rtc_ctrl_t;

  function automatic logic [DATA_W-1:0] to_bcd(input fld_t v);
    int t;
    int u;
    t = int'(v) / 10;
    u = int'(v) % 10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic fld_t from_bcd(input logic [DATA_W-1:0] b);
    int s;
    s = int'(b[7:4]) * 10 + int'(b[3:0]);
    return s[FIELD_W-1:0];
  endfunction

  function automatic fld_t month_len(input fld_t m, input fld_t y);
    fld_t r;
    case (m)
      7'd2:                      r = (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   r = 7'd30;
      default:                   r = 7'd31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_counters.sv
module rtc_counters
  import cal_rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  fld_t       wr_val,
  input  logic       dst_en,
  input  rtc_dst_t   dst,
  output rtc_time_t  cur
);
  rtc_time_t nxt;
  logic      guard, guard_n;
  logic      on_day, off_day;

  assign on_day  = (cur.month == dst.mon_on)  && (cur.date == dst.day_on);
  assign off_day = (cur.month == dst.mon_off) && (cur.date == dst.day_off);

  always_comb begin
    nxt     = cur;
    guard_n = guard;
    if (tick) begin
      if (cur.sec != SEC_TOP) begin
        nxt.sec = cur.sec + ONE;
      end else begin
        nxt.sec = '0;
        if (cur.min != MIN_TOP) begin
          nxt.min = cur.min + ONE;
        end else begin
          nxt.min = '0;
          if (cur.hour == HOUR_TOP) begin
            nxt.hour = '0;
            guard_n  = 1'b0;
            nxt.wday = (cur.wday == WDAY_TOP) ? '0 : cur.wday + ONE;
            if (cur.date != month_len(cur.month, cur.year)) begin
              nxt.date = cur.date + ONE;
            end else begin
              nxt.date = ONE;
              if (cur.month != MON_TOP) begin
                nxt.month = cur.month + ONE;
              end else begin
                nxt.month = ONE;
                nxt.year  = (cur.year == YEAR_TOP) ? '0 : cur.year + ONE;
              end
            end
          end else if (dst_en && !guard && off_day && (cur.hour == dst.hour_off)) begin
            guard_n = 1'b1;
          end else if (dst_en && on_day && ((cur.hour + ONE) == dst.hour_on)) begin
            nxt.hour = cur.hour + 7'd2;
          end else begin
            nxt.hour = cur.hour + ONE;
          end
        end
      end
    end else if (wr_en) begin
      case (wr_sel)
        3'd0:    nxt.sec   = wr_val;
        3'd1:    nxt.min   = wr_val;
        3'd2:    nxt.hour  = wr_val;
        3'd3:    nxt.date  = wr_val;
        3'd4:    nxt.wday  = wr_val;
        3'd5:    nxt.month = wr_val;
        default: nxt.year  = wr_val;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= '{sec: '0, min: '0, hour: '0, date: ONE, wday: '0, month: ONE, year: '0};
      guard <= 1'b0;
    end else begin
      cur   <= nxt;
      guard <= guard_n;
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import cal_rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rtc_time_t  cur,
  input  rtc_alarm_t alm,
  input  logic       date_match,
  input  logic       clr,
  output logic       flag
);
  logic hit_time, hit_date, hit, hit_q;

  assign hit_time = (cur.sec == alm.sec) && (cur.min == alm.min) && (cur.hour == alm.hour);
  assign hit_date = (cur.date == alm.date) && (cur.month == alm.month) && (cur.year == alm.year);
  assign hit      = hit_time && (!date_match || hit_date);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b1;
      flag  <= 1'b0;
    end else begin
      hit_q <= hit;
      flag  <= (flag && !clr) || (hit && !hit_q);
    end
  end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import cal_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  rtc_time_t         cur,
  input  logic              flag,
  output logic              time_wr,
  output logic [2:0]        time_sel,
  output fld_t              time_val,
  output rtc_ctrl_t         ctrl,
  output rtc_alarm_t        alm,
  output rtc_dst_t          dst,
  output logic              flag_clr
);
  logic              accept, do_wr;
  fld_t              wval, raw;
  logic              is_field;
  logic [DATA_W-1:0] fmt;

  assign bus_ready = !tick;
  assign accept    = bus_valid && bus_ready;
  assign do_wr     = accept && bus_write;
  assign wval      = ctrl.bcd ? from_bcd(bus_wdata) : bus_wdata[FIELD_W-1:0];

  assign time_wr   = do_wr && (bus_addr <= A_YEAR);
  assign time_sel  = bus_addr[2:0];
  assign time_val  = wval;
  assign flag_clr  = do_wr && (bus_addr == A_STAT) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      alm  <= '{sec: '0, min: '0, hour: '0, date: ONE, month: ONE, year: '0};
      dst  <= '0;
    end else if (do_wr) begin
      case (bus_addr)
        A_CTRL:  ctrl         <= bus_wdata[3:0];
        A_ASEC:  alm.sec      <= wval;
        A_AMIN:  alm.min      <= wval;
        A_AHOUR: alm.hour     <= wval;
        A_ADATE: alm.date     <= wval;
        A_AMON:  alm.month    <= wval;
        A_AYEAR: alm.year     <= wval;
        A_SMON:  dst.mon_on   <= wval;
        A_SDAY:  dst.day_on   <= wval;
        A_SHOUR: dst.hour_on  <= wval;
        A_EMON:  dst.mon_off  <= wval;
        A_EDAY:  dst.day_off  <= wval;
        A_EHOUR: dst.hour_off <= wval;
        default: ;
      endcase
    end
  end

  always_comb begin
    is_field = 1'b1;
    case (bus_addr)
      A_SEC:   raw = cur.sec;
      A_MIN:   raw = cur.min;
      A_HOUR:  raw = cur.hour;
      A_DATE:  raw = cur.date;
      A_WDAY:  raw = cur.wday;
      A_MON:   raw = cur.month;
      A_YEAR:  raw = cur.year;
      A_CTRL:  begin raw = {3'b000, ctrl}; is_field = 1'b0; end
      A_ASEC:  raw = alm.sec;
      A_AMIN:  raw = alm.min;
      A_AHOUR: raw = alm.hour;
      A_ADATE: raw = alm.date;
      A_AMON:  raw = alm.month;
      A_AYEAR: raw = alm.year;
      A_STAT:  begin raw = {6'b000000, flag}; is_field = 1'b0; end
      A_SMON:  raw = dst.mon_on;
      A_SDAY:  raw = dst.day_on;
      A_SHOUR: raw = dst.hour_on;
      A_EMON:  raw = dst.mon_off;
      A_EDAY:  raw = dst.day_off;
      A_EHOUR: raw = dst.hour_off;
      default: begin raw = '0; is_field = 1'b0; end
    endcase
    fmt = (ctrl.bcd && is_field) ? to_bcd(raw) : {1'b0, raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= accept && !bus_write;
      if (accept && !bus_write) rd_data <= fmt;
    end
  end
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              alarm_irq,
  output logic              alarm_wake
);
  rtc_time_t  cur_time;
  rtc_ctrl_t  ctrl;
  rtc_alarm_t alm;
  rtc_dst_t   dst;
  logic       time_wr, flag_clr, flag;
  logic [2:0] time_sel;
  fld_t       time_val;

  rtc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .cur(cur_time), .flag(flag),
    .time_wr(time_wr), .time_sel(time_sel), .time_val(time_val),
    .ctrl(ctrl), .alm(alm), .dst(dst), .flag_clr(flag_clr)
  );

  rtc_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
    .wr_en(time_wr), .wr_sel(time_sel), .wr_val(time_val),
    .dst_en(ctrl.dst_en), .dst(dst), .cur(cur_time)
  );

  rtc_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .cur(cur_time), .alm(alm),
    .date_match(ctrl.date_match), .clr(flag_clr), .flag(flag)
  );

  assign alarm_irq  = flag && ctrl.irq_en;
  assign alarm_wake = flag;
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
  import cal_rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      tick_1hz,
  input logic      bus_valid,
  input logic      bus_write,
  input logic      bus_ready,
  input logic      rd_valid,
  input logic      alarm_irq,
  input logic      alarm_wake,
  input rtc_time_t cur,
  input logic      time_wr,
  input logic      flag_clr
);
  // R13: no request is taken while a tick is applied
  a_r13_ready_low_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |-> !bus_ready);

  // R13: accepted read answers on the next edge
  a_r13_read_response: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_write) |=> rd_valid);

  // R10: interrupt never without the flag
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> alarm_wake);

  // R2: time fields stay in range
  a_r2_time_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.sec <= 7'd59) && (cur.min <= 7'd59) && (cur.hour <= 7'd23) && (cur.wday <= 7'd6));

  // R3: calendar fields stay in range
  a_r3_date_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.date >= 7'd1) && (cur.date <= 7'd31) && (cur.month >= 7'd1) && (cur.month <= 7'd12));

  // R6: counters move only on a tick or a write
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !time_wr) |=> $stable(cur));

  // R9: the flag drops only after a write-one-to-clear
  a_r9_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_wake) |-> $past(flag_clr));
endmodule

bind cal_rtc cal_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_ready(bus_ready),
  .rd_valid(rd_valid), .alarm_irq(alarm_irq), .alarm_wake(alarm_wake),
  .cur(cur_time), .time_wr(time_wr), .flag_clr(flag_clr)
);

// File: tb/cal_rtc_test.sv
module cal_rtc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       bus_valid = 1'b0;
  logic       bus_write = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_ready, rd_valid, alarm_irq, alarm_wake;
  logic [7:0] rd_data;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  bit bcd = 0;
  int ms, mm, mh, md, mw, mo, my;

  always #4 clk = ~clk;

  cal_rtc uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .alarm_irq(alarm_irq), .alarm_wake(alarm_wake)
  );

  function automatic int dim(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int enc(int v);
    return bcd ? ((v / 10) * 16 + (v % 10)) : v;
  endfunction

  function automatic int dec(int v);
    return bcd ? ((v / 16) * 10 + (v % 16)) : v;
  endfunction

  task automatic model_tick();
    ms++;
    if (ms == 60) begin ms = 0; mm++; end
    if (mm == 60) begin mm = 0; mh++; end
    if (mh == 24) begin
      mh = 0; mw = (mw + 1) % 7; md++;
      if (md > dim(mo, my)) begin
        md = 1; mo++;
        if (mo == 13) begin mo = 1; my = (my + 1) % 100; end
      end
    end
  endtask

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a[4:0]; bus_wdata = d[7:0];
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic wreg(int a, int v);
    wr(a, enc(v));
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a[4:0];
    @(negedge clk);
    bus_valid = 0;
    v = rd_valid ? int'(rd_data) : -1;
  endtask

  task automatic rdv(int a, output int v);
    int r;
    rd(a, r);
    v = dec(r);
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1hz = 1;
    @(negedge clk);
    tick_1hz = 0;
  endtask

  task automatic set_ctrl(int c);
    wr(7, c);
    bcd = c[0];
  endtask

  task automatic set_time(int y, int mon, int d, int w, int h, int mi, int s);
    wreg(6, y); wreg(5, mon); wreg(3, d); wreg(4, w);
    wreg(2, h); wreg(1, mi); wreg(0, s);
    my = y; mo = mon; md = d; mw = w; mh = h; mm = mi; ms = s;
  endtask

  task automatic check_time(string req);
    int v;
    rdv(0, v); check(req, v, ms);
    rdv(1, v); check(req, v, mm);
    rdv(2, v); check(req, v, mh);
    rdv(3, v); check(req, v, md);
    rdv(4, v); check(req, v, mw);
    rdv(5, v); check(req, v, mo);
    rdv(6, v); check(req, v, my);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R13 watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    ms = 0; mm = 0; mh = 0; md = 1; mw = 0; mo = 1; my = 0;
    check("R1 irq", alarm_irq, 0);
    check("R1 wake", alarm_wake, 0);
    check_time("R1");
    rd(7, v); check("R1 ctrl", v, 0);
    rd(14, v); check("R1 flag", v, 0);

    // R13: back-pressure during a tick, response strobe, unused address
    @(negedge clk); tick_1hz = 1; #1;
    check("R13 ready low on tick", bus_ready, 0);
    @(negedge clk); tick_1hz = 0; model_tick(); #1;
    check("R13 ready high", bus_ready, 1);
    rd(25, v); check("R13 unused addr", v, 0);

    // R5 / R6: BCD write, binary read back
    set_ctrl(1);
    wreg(1, 45); mm = 45;
    rd(1, v); check("R5 bcd raw read", v, 'h45);
    set_ctrl(0);
    rd(1, v); check("R5 binary read", v, 45);
    check_time("R6");

    // R2 / R3: 30-day month, weekday wrap
    set_time(21, 4, 30, 6, 23, 59, 59);
    tick(); model_tick();
    check_time("R3 april end");
    check("R2 weekday wrap", mw, 0);
    // R4: leap and non-leap February, century wrap
    set_time(24, 2, 28, 2, 23, 59, 59);
    tick(); model_tick(); check_time("R4 leap feb");
    rdv(3, v); check("R4 day 29", v, 29);
    set_time(23, 2, 28, 2, 23, 59, 59);
    tick(); model_tick();
    rdv(5, v); check("R4 non-leap march", v, 3);
    set_time(99, 12, 31, 3, 23, 59, 59);
    tick(); model_tick();
    rdv(6, v); check("R4 year wrap", v, 0);
    rdv(5, v); check("R3 month wrap", v, 1);

    // R7 / R8: summer time
    set_ctrl(8);
    wreg(15, 3); wreg(16, 10); wreg(17, 2);
    wreg(18, 11); wreg(19, 3); wreg(20, 2);
    set_time(25, 3, 10, 0, 1, 59, 59);
    tick();
    rdv(2, v); check("R7 skip hour", v, 3);
    rdv(0, v); check("R7 seconds", v, 0);
    set_time(25, 11, 3, 0, 2, 59, 59);
    tick();
    rdv(2, v); check("R8 repeat hour", v, 2);
    rdv(1, v); check("R8 minutes", v, 0);
    wreg(1, 59); wreg(0, 59);
    tick();
    rdv(2, v); check("R8 only once", v, 3);

    // R9 / R10 / R12: alarm
    set_ctrl(0);
    wreg(8, 32); wreg(9, 20); wreg(10, 10);
    set_time(10, 5, 5, 1, 10, 20, 30);
    wr(14, 1);
    tick(); repeat (2) @(negedge clk);
    check("R9 no early flag", alarm_wake, 0);
    tick(); repeat (2) @(negedge clk);
    check("R12 wake without enable", alarm_wake, 1);
    check("R10 irq disabled", alarm_irq, 0);
    set_ctrl(2); @(negedge clk);
    check("R10 irq enabled", alarm_irq, 1);
    tick(); repeat (2) @(negedge clk);
    check("R9 sticky", alarm_wake, 1);
    wr(14, 1); @(negedge clk);
    check("R9 cleared", alarm_wake, 0);
    check("R10 irq follows flag", alarm_irq, 0);
    wreg(0, 32); repeat (2) @(negedge clk);
    check("R9 reset on new match", alarm_wake, 1);
    wr(14, 1); repeat (2) @(negedge clk);
    rd(14, v); check("R9 held match no re-set", v, 0);

    // R11: date-qualified alarm
    set_ctrl(6);
    wreg(8, 0); wreg(9, 0); wreg(10, 8);
    wreg(11, 5); wreg(12, 6); wreg(13, 7);
    set_time(7, 6, 4, 0, 7, 59, 59);
    wr(14, 1);
    tick(); repeat (2) @(negedge clk);
    check("R11 wrong date", alarm_wake, 0);
    wreg(3, 5); repeat (2) @(negedge clk);
    check("R11 date matches", alarm_wake, 1);
    check("R11 irq", alarm_irq, 1);
    wr(14, 1);

    // Random runs against the bench model
    for (int it = 0; it < 14; it++) begin
      int y, mon, d, n;
      set_ctrl(($urandom % 2) ? 1 : 0);
      y = $urandom % 100;
      mon = 1 + $urandom % 12;
      d = ($urandom % 2) ? dim(mon, y) : 1 + $urandom % dim(mon, y);
      set_time(y, mon, d, $urandom % 7, ($urandom % 2) ? 23 : $urandom % 24,
               50 + $urandom % 10, $urandom % 60);
      n = 1 + $urandom % 1500;
      for (int k = 0; k < n; k++) begin
        tick(); model_tick();
      end
      check_time("R2 R3 R4 R5 random");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule